// File: doc/BRIEF.md
# Binary Set Operation Routing Stage

This stage closes a reconfigurable binary compute unit. Upstream window logic delivers, for each group of pixels, five binary results: the original input pixel, two logic-element results, a reduction result and a median result. Two operand selectors pick the A and B inputs of a set-algebra element. That element computes union, intersection, complement, subtraction, XOR or a pass-through. An output selector then picks the signal handed to the next unit in the chain. Chaining units this way builds compound morphology. Hit-and-miss, for example, is the intersection of one erosion of the image with a second erosion of its complement, each erosion produced by an earlier unit.

The stage processes `PIX_W` pixels per beat and adds one register of latency. The valid, line-start and frame-start flags travel with the data. A configuration word is captured only on a valid frame-start beat and governs that beat and every later beat until the next valid frame start. A frame is therefore never processed with mixed settings.

Top module: `bsr_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sol`, `out_sof` and `out_pix` are 0 after the clock edge. After reset the held configuration is all zeros.
- R2: `out_valid`, `out_sol` and `out_sof` equal `in_valid`, `in_sol` and `in_sof` from the previous clock cycle. `out_pix` is the result for the beat presented one cycle earlier.
- R3: When `out_valid` is 0, `out_pix` is 0.
- R4: Set code `cfg_op`: 000 gives A|B, 001 gives A&B, 010 gives ~A, 011 gives A&~B, 100 gives A^B, and 101 passes A through.
- R5: Operand selects `cfg_sel_a` and `cfg_sel_b`: 000 picks `pix_lga`, 001 picks `pix_lgb`, 010 picks `pix_red`, 011 picks `pix_med`.
- R6: Output select `cfg_sel_out`: 000 picks `pix_orig`, 001 picks `pix_lga`, 010 picks `pix_lgb`, 011 picks `pix_red`, 100 picks `pix_med`, 101 picks the set result.
- R7: Unassigned codes give all-zero data. This covers operand selects 100 to 111, set codes 110 and 111, and output selects 110 and 111.
- R8: The configuration inputs are captured only on a beat with `in_valid` and `in_sof` both 1, and they apply from that beat on. Configuration changes on any other beat, including a frame-start beat with `in_valid` 0, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sol | input | 1 | Input line-start flag |
| in_sof | input | 1 | Input frame-start flag |
| pix_orig | input | PIX_W | Original input pixels |
| pix_lga | input | PIX_W | First logic-element result |
| pix_lgb | input | PIX_W | Second logic-element result |
| pix_red | input | PIX_W | Reduction result |
| pix_med | input | PIX_W | Median result |
| cfg_sel_a | input | 3 | Operand A select code |
| cfg_sel_b | input | 3 | Operand B select code |
| cfg_op | input | 3 | Set operation code |
| cfg_sel_out | input | 3 | Output select code |
| out_valid | output | 1 | Output beat valid |
| out_sol | output | 1 | Delayed line-start flag |
| out_sof | output | 1 | Delayed frame-start flag |
| out_pix | output | PIX_W | Selected result to the next unit |

## Verification
On every cycle, the assertions check the one-cycle flag delay and the zero data on idle beats. They also check that unassigned output codes give zero, that an intersection result never sets a bit outside operand A, and that the held configuration changes only on a valid frame-start beat. Only the bench's sweep can show that every code in all four fields picks the intended source and function. The same holds for configuration writes on mid-frame beats or on invalid frame-start beats, which must leave the output unchanged.

// File: rtl/bsr_pkg.sv
// Shared encodings for the binary set routing stage.
// Assumes 3-bit codes for every configuration field.
package bsr_pkg;
    localparam int SEL_W    = 3;
    localparam int NSRC_OPD = 4;  // operand sources: lga, lgb, red, med
    localparam int NSRC_OUT = 6;  // output sources: orig, lga, lgb, red, med, set

    typedef enum logic [SEL_W-1:0] {
        SOP_UNION  = 3'b000,
        SOP_INTER  = 3'b001,
        SOP_COMPL  = 3'b010,
        SOP_SUBTR  = 3'b011,
        SOP_XOR    = 3'b100,
        SOP_PASS_A = 3'b101
    } set_op_e;

    localparam logic [SEL_W-1:0] OUT_SEL_SET = 3'b101;

    typedef struct packed {
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] op;
        logic [SEL_W-1:0] sel_out;
    } stage_cfg_t;
endpackage

// File: rtl/bsr_cfg_hold.sv
// Configuration holder: captures the configuration word on a load beat and
// presents the effective word (the new one on the load beat itself, the
// held one otherwise). Assumes load is asserted only on valid frame starts.
module bsr_cfg_hold
    import bsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  stage_cfg_t cfg_in,
    output stage_cfg_t cfg_eff
);
    stage_cfg_t held;

    // Capture the configuration on a frame-start load beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (load)
            held <= cfg_in;
    end

    // Forward the new word on the load beat, else the held word.
    always_comb begin
        cfg_eff = load ? cfg_in : held;
    end

    // R8: held configuration only moves on a load beat
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));
endmodule

// File: rtl/bsr_pick.sv
// Source selector: returns source number sel of NSRC candidates, or all
// zeros for a code at or above NSRC. Assumes NSRC fits in SEL_W bits.
module bsr_pick #(
    parameter int W     = 4,
    parameter int NSRC  = 4,
    parameter int SEL_W = 3
) (
    input  logic [NSRC-1:0][W-1:0] src,
    input  logic [SEL_W-1:0]       sel,
    output logic [W-1:0]           dout
);
    // Match the code against each source index; unmatched codes give zero.
    always_comb begin
        dout = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i))
                dout = src[i];
        end
    end
endmodule

// File: rtl/bsr_set_alu.sv
// Set-algebra element: bitwise union, intersection, complement of A,
// A minus B, XOR or pass A. Unassigned codes give zero. Purely combinational.
module bsr_set_alu
    import bsr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [SEL_W-1:0] op,
    output logic [W-1:0]     res
);
    // Decode the set function.
    always_comb begin
        case (op)
            SOP_UNION:  res = opa | opb;
            SOP_INTER:  res = opa & opb;
            SOP_COMPL:  res = ~opa;
            SOP_SUBTR:  res = opa & ~opb;
            SOP_XOR:    res = opa ^ opb;
            SOP_PASS_A: res = opa;
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/bsr_stage.sv
// Binary set routing stage: picks two operands from the unit's internal
// results, applies a set function and routes one source to the output
// through a single register. The configuration is taken only on valid
// frame-start beats. Assumes upstream results are already time-aligned.
module bsr_stage
    import bsr_pkg::*;
#(
    parameter int PIX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] pix_orig,
    input  logic [PIX_W-1:0] pix_lga,
    input  logic [PIX_W-1:0] pix_lgb,
    input  logic [PIX_W-1:0] pix_red,
    input  logic [PIX_W-1:0] pix_med,
    input  logic [2:0]       cfg_sel_a,
    input  logic [2:0]       cfg_sel_b,
    input  logic [2:0]       cfg_op,
    input  logic [2:0]       cfg_sel_out,
    output logic             out_valid,
    output logic             out_sol,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pix
);
    stage_cfg_t cfg_new, cfg_eff;
    logic       cfg_load;
    logic [NSRC_OPD-1:0][PIX_W-1:0] opd_src;
    logic [NSRC_OUT-1:0][PIX_W-1:0] out_src;
    logic [PIX_W-1:0] opa, opb, set_res, routed;

    // Gather the configuration fields and the load condition.
    always_comb begin
        cfg_new  = '{sel_a: cfg_sel_a, sel_b: cfg_sel_b,
                     op: cfg_op, sel_out: cfg_sel_out};
        cfg_load = in_valid & in_sof;
    end

    bsr_cfg_hold u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .cfg_in(cfg_new), .cfg_eff(cfg_eff)
    );

    // Order the candidate sources to match the select codes.
    always_comb begin
        opd_src = {pix_med, pix_red, pix_lgb, pix_lga};
        out_src = {set_res, pix_med, pix_red, pix_lgb, pix_lga, pix_orig};
    end

    bsr_pick #(.W(PIX_W), .NSRC(NSRC_OPD), .SEL_W(SEL_W)) u_pick_a (
        .src(opd_src), .sel(cfg_eff.sel_a), .dout(opa)
    );
    bsr_pick #(.W(PIX_W), .NSRC(NSRC_OPD), .SEL_W(SEL_W)) u_pick_b (
        .src(opd_src), .sel(cfg_eff.sel_b), .dout(opb)
    );
    bsr_set_alu #(.W(PIX_W)) u_alu (
        .opa(opa), .opb(opb), .op(cfg_eff.op), .res(set_res)
    );
    bsr_pick #(.W(PIX_W), .NSRC(NSRC_OUT), .SEL_W(SEL_W)) u_pick_out (
        .src(out_src), .sel(cfg_eff.sel_out), .dout(routed)
    );

    // Output register: data gated by valid, flags delayed as they arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_sol   <= in_sol;
            out_sof   <= in_sof;
            out_pix   <= in_valid ? routed : '0;
        end
    end

    // R2: flags are delayed by exactly one cycle
    a_r2_flag_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)) &&
                         (out_sol == $past(in_sol)) && (out_sof == $past(in_sof)));
    // R3: idle beats carry no data
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_pix == '0);
    // R7: unassigned output codes give zero
    a_r7_unassigned_out: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_eff.sel_out > OUT_SEL_SET) |=> out_pix == '0);
    // R4: an intersection routed out never sets a bit outside operand A
    a_r4_inter_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_eff.sel_out == OUT_SEL_SET && cfg_eff.op == SOP_INTER)
        |=> (out_pix & ~$past(opa)) == '0);
endmodule

// File: tb/bsr_stage_test.sv
// Sweep of every configuration word with mid-frame and invalid-beat writes.
module bsr_stage_test;
    localparam int W = 4;
    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_sol = 0, in_sof = 0;
    logic [W-1:0] p_orig = 0, p_lga = 0, p_lgb = 0, p_red = 0, p_med = 0;
    logic [11:0] cfg = 0;
    logic out_valid, out_sol, out_sof;
    logic [W-1:0] out_pix;
    int checks = 0, errors = 0;
    int cycles = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    bsr_stage #(.PIX_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_sof(in_sof), .pix_orig(p_orig), .pix_lga(p_lga), .pix_lgb(p_lgb),
        .pix_red(p_red), .pix_med(p_med), .cfg_sel_a(cfg[11:9]),
        .cfg_sel_b(cfg[8:6]), .cfg_op(cfg[5:3]), .cfg_sel_out(cfg[2:0]),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof),
        .out_pix(out_pix)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] opd(input logic [2:0] s);
        case (s)
            3'd0: return p_lga;
            3'd1: return p_lgb;
            3'd2: return p_red;
            3'd3: return p_med;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] model(input logic [11:0] c);
        logic [W-1:0] a, b, s;
        a = opd(c[11:9]);
        b = opd(c[8:6]);
        case (c[5:3])
            3'd0: s = a | b;
            3'd1: s = a & b;
            3'd2: s = ~a;
            3'd3: s = a & ~b;
            3'd4: s = a ^ b;
            3'd5: s = a;
            default: s = '0;
        endcase
        case (c[2:0])
            3'd0: return p_orig;
            3'd1: return p_lga;
            3'd2: return p_lgb;
            3'd3: return p_red;
            3'd4: return p_med;
            3'd5: return s;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] c);
        if (c[2:0] > 3'd5) return "R7";
        if (c[2:0] != 3'd5) return "R6";
        if (c[5:3] > 3'd5 || c[11:9] > 3'd3 || c[8:6] > 3'd3) return "R7";
        if (c[5:3] == 3'd5) return "R5";
        return "R4";
    endfunction

    // One beat: drive at negedge, sample just after the capturing edge.
    task automatic beat(input logic v, input logic sol, input logic sof,
                        input logic [11:0] c_drive, input logic [11:0] c_exp,
                        input string tag);
        logic [W-1:0] expd;
        @(negedge clk);
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        {p_orig, p_lga, p_lgb, p_red, p_med} = rng[19:0];
        in_valid = v; in_sol = sol; in_sof = sof; cfg = c_drive;
        #1;
        expd = v ? model(c_exp) : '0;
        @(posedge clk); #1;
        check("R2", {29'd0, out_valid, out_sol, out_sof}, {29'd0, v, sol, sof});
        check(v ? tag : "R3", {28'd0, out_pix}, {28'd0, expd});
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state with active inputs held
        in_valid = 1; in_sof = 1; in_sol = 1; p_orig = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {29'd0, out_valid, out_sol, out_sof}, 32'd0);
        check("R1", {28'd0, out_pix}, 32'd0);
        @(negedge clk);
        rst_n = 1; in_valid = 0; in_sof = 0; in_sol = 0;
        // R1: held config is zero after reset (out select 0 passes original)
        beat(1, 0, 0, 12'hFFF, 12'h000, "R1");
        for (int c = 0; c < 4096; c++) begin
            logic [11:0] cw = 12'(c);
            beat(1, 1, 1, cw, cw, tag_of(cw));
            beat(1, 0, 0, cw ^ 12'hFFF, cw, "R8");
            beat(0, 0, 1, cw ^ 12'hA5A, cw, "R3");
            beat(1, 1, 0, cw ^ 12'h5A5, cw, "R8");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule